// File: doc/BRIEF.md
# Flash Command Sequencer with Operation Queue and Block Locks

This block sits between a host bus and a block-erasable flash array model. The host issues byte-wide bus writes. The block turns pairs of writes into operations: byte program, single-block erase, erase of every unlocked block, and lock-bit set. It also takes a one-write command that clears the error flags. Every program or erase stands in for real array time with a countdown whose length the host supplies on `op_time` when the operation starts.

The block has two execution engines. The write engine runs programs and lock-sets. The erase engine runs single erases and full sweeps. A single holding slot stores the next request while work is in progress. A queued program may start early, alongside a running single-block erase, when the two target different blocks. Each of the 32 blocks has a lock bit. The lock bit refuses programs and erases only while `wr_protect` is high. The full sweep always skips locked blocks. Completions leave on two strobes: one for programs and one for erased blocks. Progress and sticky error flags appear on `status` and `ready`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `ready` is 1 and `status` is 8'h80. The status bits are: [7] ready, [6] slot occupied, [5] write engine busy, [4] erase engine busy, [3] sequence error, [2] operation error, [1] protect error, [0] queue full.
- R2: The write 8'h40 followed by a write of data D at address A programs one location. Exactly one `prog_done` pulse follows, with `prog_addr`=A and `prog_data`=D. The block number is address bits [20:16].
- R3: The write 8'h20 followed by 8'h D0 at an address inside block B erases that block. Exactly one `erase_done` pulse follows, with `erase_blk`=B.
- R4: If the second write after 8'h20, 8'hA7 or 8'h77 is anything other than 8'hD0, no operation starts, `ready` stays 1 and status bit 3 is set.
- R5: An operation confirmed while another runs waits in the slot and runs after it, in order. A request that arrives while the slot is still occupied is dropped and sets status bit 0.
- R6: A queued program whose block differs from that of a running single-block erase starts at once, in parallel with the erase. The two completions may coincide in one cycle.
- R7: The write 8'h77 followed by 8'hD0 at an address in block B sets the lock bit of B. While `wr_protect` is 1, a program or single erase aimed at a locked block produces no completion and sets status bits 1 and 2.
- R8: While `wr_protect` is 0, lock bits do not stop programs or single erases.
- R9: The write 8'hA7 followed by 8'hD0 erases, in ascending order, every block whose lock bit is clear. It gives one `erase_done` per block and skips locked blocks whatever `wr_protect` is.
- R10: The one-write command 8'h50 clears status bits 0 to 3.
- R11: `ready` is 0 while any operation is queued or running. An engine reports completion in the `op_time`-th cycle after it starts. An `op_time` of 0 counts as 1.
- R12: Status bits 0 to 3 stay set until an 8'h50 command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | One-cycle host write strobe |
| bus_addr | input | 21 | Host address: block in [20:16], offset below |
| bus_data | input | 8 | Host write data or command code |
| wr_protect | input | 1 | High: locked blocks refuse program and erase |
| op_time | input | 16 | Cycles per program/erase step, sampled at start |
| ready | output | 1 | High when nothing is queued or running |
| status | output | 8 | Status flags, layout in R1 |
| prog_done | output | 1 | Program completion strobe |
| prog_addr | output | 21 | Address of the completed program |
| prog_data | output | 8 | Data of the completed program |
| erase_done | output | 1 | Block-erase completion strobe |
| erase_blk | output | 5 | Block just erased |

## Verification
The case that matters most is a program completion and a block-erase completion arriving in the same cycle. That can only happen when the program has started early beside a running erase. The bench confirms an erase of block 5 with a 10-cycle time. It then confirms a program to block 6 four cycles later and lowers `op_time` to 6 between the two starts. Both strobes are then due in the same cycle. The scoreboard monitor pops both expected items at one sampling point and records that they coincided. Any slip in the start rule or the countdown splits them apart, and that is reported as a failure.

// File: rtl/fci_pkg.sv
// Shared command codes and operation kinds for the flash command sequencer.
// Assumes an 8-bit command field on the host data bus.
package fci_pkg;
    localparam logic [7:0] CMD_PROG    = 8'h40;
    localparam logic [7:0] CMD_ERASE   = 8'h20;
    localparam logic [7:0] CMD_CONFIRM = 8'hD0;
    localparam logic [7:0] CMD_SWEEP   = 8'hA7;
    localparam logic [7:0] CMD_LOCK    = 8'h77;
    localparam logic [7:0] CMD_CLEAR   = 8'h50;

    typedef enum logic [1:0] {
        K_PROG  = 2'd0,
        K_ERASE = 2'd1,
        K_ALL   = 2'd2,
        K_LOCK  = 2'd3
    } op_kind_e;
endpackage

// File: rtl/fci_decoder.sv
// Two-write command decoder. It tracks which setup code was seen and emits one
// request on the write that completes a sequence. Assumes bus_we is a
// single-cycle strobe. Outputs are combinational from the bus and the state.
module fci_decoder import fci_pkg::*; #(
    parameter int BLK_W  = 5,
    parameter int OFFS_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_we,
    input  logic [BLK_W+OFFS_W-1:0] bus_addr,
    input  logic [DATA_W-1:0]       bus_data,
    output logic                    req_v,
    output op_kind_e                req_kind,
    output logic [BLK_W-1:0]        req_blk,
    output logic [OFFS_W-1:0]       req_offs,
    output logic [DATA_W-1:0]       req_data,
    output logic                    clr,
    output logic                    seq_err
);
    typedef enum logic [2:0] {S_IDLE, S_PROG, S_ERASE, S_ALL, S_LOCK} dec_st_e;
    dec_st_e st_q, st_d;

    assign req_blk  = (st_q == S_ALL) ? '0 : bus_addr[BLK_W+OFFS_W-1:OFFS_W];
    assign req_offs = bus_addr[OFFS_W-1:0];
    assign req_data = bus_data;

    // Next-state and request decode for each host write.
    always_comb begin
        st_d     = st_q;
        req_v    = 1'b0;
        req_kind = K_PROG;
        clr      = 1'b0;
        seq_err  = 1'b0;
        if (bus_we) begin
            case (st_q)
                S_IDLE: begin
                    if (bus_data == DATA_W'(CMD_PROG))       st_d = S_PROG;
                    else if (bus_data == DATA_W'(CMD_ERASE)) st_d = S_ERASE;
                    else if (bus_data == DATA_W'(CMD_SWEEP)) st_d = S_ALL;
                    else if (bus_data == DATA_W'(CMD_LOCK))  st_d = S_LOCK;
                    else if (bus_data == DATA_W'(CMD_CLEAR)) clr  = 1'b1;
                end
                S_PROG: begin
                    req_v = 1'b1;
                    st_d  = S_IDLE;
                end
                default: begin
                    st_d = S_IDLE;
                    if (bus_data == DATA_W'(CMD_CONFIRM)) begin
                        req_v    = 1'b1;
                        req_kind = (st_q == S_ERASE) ? K_ERASE :
                                   (st_q == S_ALL)   ? K_ALL   : K_LOCK;
                    end else begin
                        seq_err = 1'b1;
                    end
                end
            endcase
        end
    end

    // Sequence state register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fci_lockbits.sv
// Per-block lock flags. A bit is set by a completed lock operation and is
// cleared only by reset. This model has no separate power-up image.
module fci_lockbits #(
    parameter int NBLK  = 32,
    parameter int BLK_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_v,
    input  logic [BLK_W-1:0] set_blk,
    output logic [NBLK-1:0]  locks
);
    for (genvar i = 0; i < NBLK; i++) begin : g_bit
        logic bit_q;
        // Hold one block's lock flag.
        always_ff @(posedge clk) begin
            if (!rst_n)                                 bit_q <= 1'b0;
            else if (set_v && set_blk == BLK_W'(i))     bit_q <= 1'b1;
        end
        assign locks[i] = bit_q;
    end
endmodule

// File: rtl/fci_engine.sv
// Countdown engine for one operation. It latches the step time when it starts
// (zero counts as one) and pulses step_done in the last cycle of each step.
// For a sweep it walks the blocks upward, spending one cycle on each locked
// block and raising no pulse for it.
module fci_engine import fci_pkg::*; #(
    parameter int NBLK  = 32,
    parameter int BLK_W = 5,
    parameter int TW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  op_kind_e         in_kind,
    input  logic [BLK_W-1:0] in_blk,
    input  logic [TW-1:0]    t_in,
    input  logic [NBLK-1:0]  locks,
    output logic             busy,
    output op_kind_e         kind,
    output logic [BLK_W-1:0] blk,
    output logic             step_done
);
    logic [TW-1:0] cnt_q, t_q, t_clamp;
    logic sweep, skip, last;

    assign t_clamp   = (t_in == '0) ? TW'(1) : t_in;
    assign sweep     = (kind == K_ALL);
    assign skip      = busy && sweep && locks[blk];
    assign last      = (blk == BLK_W'(NBLK - 1));
    assign step_done = busy && !skip && (cnt_q == TW'(1));

    // Start, count down, and step through the blocks during a sweep.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            kind  <= K_PROG;
            blk   <= '0;
            cnt_q <= '0;
            t_q   <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            kind  <= in_kind;
            blk   <= in_blk;
            cnt_q <= t_clamp;
            t_q   <= t_clamp;
        end else if (busy) begin
            if (skip || step_done) begin
                if (sweep && !last) begin
                    blk   <= blk + 1'b1;
                    cnt_q <= t_q;
                end else begin
                    busy <= 1'b0;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/flash_cmd_ctrl.sv
// Flash command sequencer top. It decodes host sequences into a one-entry
// holding slot and dispatches from the slot to a write engine (program, lock)
// or an erase engine (erase, sweep). It checks lock bits against write protect
// at dispatch and keeps sticky error flags. Assumes 8-bit commands in bus_data.
module flash_cmd_ctrl import fci_pkg::*; #(
    parameter int NBLK   = 32,
    parameter int OFFS_W = 16,
    parameter int DATA_W = 8,
    parameter int TW     = 16
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bus_we,
    input  logic [$clog2(NBLK)+OFFS_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]                bus_data,
    input  logic                             wr_protect,
    input  logic [TW-1:0]                    op_time,
    output logic                             ready,
    output logic [7:0]                       status,
    output logic                             prog_done,
    output logic [$clog2(NBLK)+OFFS_W-1:0]   prog_addr,
    output logic [DATA_W-1:0]                prog_data,
    output logic                             erase_done,
    output logic [$clog2(NBLK)-1:0]          erase_blk
);
    localparam int BLK_W = $clog2(NBLK);

    logic              req_v, clr, seq_err;
    op_kind_e          req_kind;
    logic [BLK_W-1:0]  req_blk;
    logic [OFFS_W-1:0] req_offs;
    logic [DATA_W-1:0] req_data;

    logic              slot_v;
    op_kind_e          slot_kind;
    logic [BLK_W-1:0]  slot_blk;
    logic [OFFS_W-1:0] slot_offs;
    logic [DATA_W-1:0] slot_data;

    logic [NBLK-1:0]   locks;
    logic              wr_busy, wr_step, er_busy, er_step;
    op_kind_e          wr_kind, er_kind;
    logic [BLK_W-1:0]  wr_blk, er_blk;
    logic [OFFS_W-1:0] wr_offs_q;
    logic [DATA_W-1:0] wr_data_q;

    logic par_ok, can_go, blocked, go, refuse, launch, start_wr, start_er;
    logic acc, qfull_set, lock_set;
    logic st_qfull, st_prot, st_oper, st_seq;

    fci_decoder #(.BLK_W(BLK_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_data(bus_data), .req_v(req_v), .req_kind(req_kind),
        .req_blk(req_blk), .req_offs(req_offs), .req_data(req_data),
        .clr(clr), .seq_err(seq_err)
    );

    fci_lockbits #(.NBLK(NBLK), .BLK_W(BLK_W)) u_locks (
        .clk(clk), .rst_n(rst_n), .set_v(lock_set), .set_blk(wr_blk),
        .locks(locks)
    );

    fci_engine #(.NBLK(NBLK), .BLK_W(BLK_W), .TW(TW)) u_wr_eng (
        .clk(clk), .rst_n(rst_n), .start(start_wr), .in_kind(slot_kind),
        .in_blk(slot_blk), .t_in(op_time), .locks(locks), .busy(wr_busy),
        .kind(wr_kind), .blk(wr_blk), .step_done(wr_step)
    );

    fci_engine #(.NBLK(NBLK), .BLK_W(BLK_W), .TW(TW)) u_er_eng (
        .clk(clk), .rst_n(rst_n), .start(start_er), .in_kind(slot_kind),
        .in_blk(slot_blk), .t_in(op_time), .locks(locks), .busy(er_busy),
        .kind(er_kind), .blk(er_blk), .step_done(er_step)
    );

    // Dispatch rule: run alone, or run a program beside a single erase elsewhere.
    always_comb begin
        par_ok   = (slot_kind == K_PROG) && !wr_busy && er_busy &&
                   (er_kind == K_ERASE) && (er_blk != slot_blk);
        can_go   = (!wr_busy && !er_busy) || par_ok;
        blocked  = wr_protect && locks[slot_blk] &&
                   (slot_kind == K_PROG || slot_kind == K_ERASE);
        go       = slot_v && can_go;
        refuse   = go && blocked;
        launch   = go && !blocked;
        start_wr = launch && (slot_kind == K_PROG || slot_kind == K_LOCK);
        start_er = launch && (slot_kind == K_ERASE || slot_kind == K_ALL);
        acc      = req_v && (!slot_v || go);
        qfull_set = req_v && !acc;
        lock_set = wr_step && (wr_kind == K_LOCK);
    end

    // Holding slot: load on acceptance, empty on dispatch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_v    <= 1'b0;
            slot_kind <= K_PROG;
            slot_blk  <= '0;
            slot_offs <= '0;
            slot_data <= '0;
        end else if (acc) begin
            slot_v    <= 1'b1;
            slot_kind <= req_kind;
            slot_blk  <= req_blk;
            slot_offs <= req_offs;
            slot_data <= req_data;
        end else if (go) begin
            slot_v <= 1'b0;
        end
    end

    // Program payload captured as the write engine starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_offs_q <= '0;
            wr_data_q <= '0;
        end else if (start_wr) begin
            wr_offs_q <= slot_offs;
            wr_data_q <= slot_data;
        end
    end

    // Sticky error flags: a set beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_qfull <= 1'b0;
            st_prot  <= 1'b0;
            st_oper  <= 1'b0;
            st_seq   <= 1'b0;
        end else begin
            st_qfull <= (st_qfull && !clr) || qfull_set;
            st_prot  <= (st_prot  && !clr) || refuse;
            st_oper  <= (st_oper  && !clr) || refuse;
            st_seq   <= (st_seq   && !clr) || seq_err;
        end
    end

    assign ready      = !(slot_v || wr_busy || er_busy);
    assign status     = {ready, slot_v, wr_busy, er_busy, st_seq, st_oper, st_prot, st_qfull};
    assign prog_done  = wr_step && (wr_kind == K_PROG);
    assign prog_addr  = {wr_blk, wr_offs_q};
    assign prog_data  = wr_data_q;
    assign erase_done = er_step;
    assign erase_blk  = er_blk;
endmodule

// File: rtl/fci_checker.sv
// Temporal checks on the flash command sequencer, attached by bind.
module fci_checker import fci_pkg::*; #(
    parameter int NBLK   = 32,
    parameter int BLK_W  = 5,
    parameter int OFFS_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ready,
    input logic [7:0]              status,
    input logic                    acc,
    input logic                    clr,
    input logic                    prog_done,
    input logic [BLK_W+OFFS_W-1:0] prog_addr,
    input logic                    erase_done,
    input logic [BLK_W-1:0]        erase_blk,
    input op_kind_e                er_kind,
    input logic [NBLK-1:0]         locks
);
    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> !ready); // R11
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_done || erase_done) |-> !ready); // R11
    AST_PROTECT_WITH_OPERR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[1]) |-> status[2]); // R7
    AST_SWEEP_SKIPS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_done && er_kind == K_ALL) |-> !locks[erase_blk]); // R9
    AST_PARALLEL_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_done && erase_done) |-> (prog_addr[BLK_W+OFFS_W-1:OFFS_W] != erase_blk)); // R6
    AST_QFULL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !clr) |=> status[0]); // R12
    AST_SEQERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && !clr) |=> status[3]); // R12
endmodule

bind flash_cmd_ctrl fci_checker #(.NBLK(NBLK), .BLK_W(BLK_W), .OFFS_W(OFFS_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ready(ready), .status(status), .acc(acc),
    .clr(clr), .prog_done(prog_done), .prog_addr(prog_addr),
    .erase_done(erase_done), .erase_blk(erase_blk), .er_kind(er_kind),
    .locks(locks)
);

// File: tb/flash_cmd_ctrl_bench.sv
// Scoreboard bench: driver tasks queue expected completions and a monitor
// pops and compares them as the strobes appear.
module flash_cmd_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [20:0] bus_addr = '0;
    logic [7:0]  bus_data = '0;
    logic        wr_protect = 1'b0;
    logic [15:0] op_time = 16'd4;
    logic        ready, prog_done, erase_done;
    logic [7:0]  status, prog_data;
    logic [20:0] prog_addr;
    logic [4:0]  erase_blk;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit both_seen = 1'b0;
    bit done_flag = 1'b0;
    logic [28:0] exp_prog[$];
    logic [4:0]  exp_erase[$];

    flash_cmd_ctrl u_flash_cmd_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_data(bus_data), .wr_protect(wr_protect), .op_time(op_time),
        .ready(ready), .status(status), .prog_done(prog_done),
        .prog_addr(prog_addr), .prog_data(prog_data),
        .erase_done(erase_done), .erase_blk(erase_blk)
    );

    always #2 clk = ~clk;

    function automatic logic [20:0] mk(input int b, input int off);
        return {5'(b), 16'(off)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [20:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_data = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic do_prog(input int b, input int off, input logic [7:0] d, input bit expect_it);
        bus_wr(mk(b, 0), 8'h40);
        bus_wr(mk(b, off), d);
        if (expect_it) exp_prog.push_back({mk(b, off), d});
    endtask

    task automatic do_two(input logic [7:0] setup, input int b, input logic [7:0] conf);
        bus_wr(mk(b, 0), setup);
        bus_wr(mk(b, 0), conf);
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        @(negedge clk);
        while (!ready && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(ready == 1'b1, req, {31'd0, ready}, 32'd1);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Monitor: pop and compare completions away from the clock edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (prog_done && erase_done) both_seen = 1'b1;
            if (prog_done) begin
                if (exp_prog.size() == 0) begin
                    check(1'b0, "R2/R7 unexpected program", {3'd0, prog_addr, prog_data}, 32'd0);
                end else begin
                    logic [28:0] e;
                    e = exp_prog.pop_front();
                    check({prog_addr, prog_data} == e, "R2 program payload",
                          {3'd0, prog_addr, prog_data}, {3'd0, e});
                end
            end
            if (erase_done) begin
                if (exp_erase.size() == 0) begin
                    check(1'b0, "R3/R9 unexpected erase", {27'd0, erase_blk}, 32'd0);
                end else begin
                    logic [4:0] e;
                    e = exp_erase.pop_front();
                    check(erase_blk == e, "R3/R9 erase block", {27'd0, erase_blk}, {27'd0, e});
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        wait (cycles >= 100000 || done_flag);
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(ready == 1'b1, "R1 ready", {31'd0, ready}, 32'd1);
        check(status == 8'h80, "R1 status", {24'd0, status}, 32'h80);

        // R2 program plus R11 ready low while running
        op_time = 16'd5;
        do_prog(3, 16'h1234, 8'hA5, 1'b1);
        check(ready == 1'b0, "R11 ready low", {31'd0, ready}, 32'd0);
        wait_idle("R2 idle");
        check(exp_prog.size() == 0, "R2 completion seen", exp_prog.size(), 32'd0);

        // R11 op_time of zero treated as one
        op_time = 16'd0;
        do_prog(9, 16'h0007, 8'h3C, 1'b1);
        wait_idle("R11 zero time idle");
        check(exp_prog.size() == 0, "R11 zero time completion", exp_prog.size(), 32'd0);

        // R3 block erase
        op_time = 16'd6;
        exp_erase.push_back(5'd3);
        do_two(8'h20, 3, 8'hD0);
        wait_idle("R3 idle");
        check(exp_erase.size() == 0, "R3 completion seen", exp_erase.size(), 32'd0);

        // R4 wrong confirm, then R10 clear
        do_two(8'h20, 4, 8'h11);
        check(ready == 1'b1, "R4 stays ready", {31'd0, ready}, 32'd1);
        check(status == 8'h88, "R4 sequence error", {24'd0, status}, 32'h88);
        bus_wr(mk(0, 0), 8'h50);
        check(status == 8'h80, "R10 clear", {24'd0, status}, 32'h80);

        // R5 queue of one; third request dropped
        op_time = 16'd20;
        do_prog(1, 16'h0010, 8'h11, 1'b1);
        do_prog(2, 16'h0020, 8'h22, 1'b1);
        do_prog(4, 16'h0040, 8'h44, 1'b0);
        check(status[0] == 1'b1, "R5 queue full bit", {31'd0, status[0]}, 32'd1);
        wait_idle("R5 idle");
        check(exp_prog.size() == 0, "R5 queued op ran", exp_prog.size(), 32'd0);
        check(status == 8'h81, "R12 queue full sticky", {24'd0, status}, 32'h81);
        bus_wr(mk(0, 0), 8'h50);
        check(status == 8'h80, "R10 clear after full", {24'd0, status}, 32'h80);

        // R6 parallel program beside erase; completions coincide
        op_time = 16'd10;
        exp_erase.push_back(5'd5);
        do_two(8'h20, 5, 8'hD0);
        bus_wr(mk(6, 0), 8'h40);
        op_time = 16'd6;
        bus_wr(mk(6, 16'h0123), 8'h5A);
        exp_prog.push_back({mk(6, 16'h0123), 8'h5A});
        wait_idle("R6 idle");
        check(both_seen == 1'b1, "R6 same-cycle completions", {31'd0, both_seen}, 32'd1);
        check(exp_prog.size() + exp_erase.size() == 0, "R6 both done",
              exp_prog.size() + exp_erase.size(), 32'd0);

        // R7 lock block 7, then refuse under protect
        op_time = 16'd3;
        do_two(8'h77, 7, 8'hD0);
        wait_idle("R7 lock idle");
        wr_protect = 1'b1;
        do_prog(7, 16'h0001, 8'h77, 1'b0);
        wait_idle("R7 refuse idle");
        check(status == 8'h86, "R7 protect and op error", {24'd0, status}, 32'h86);
        do_two(8'h20, 7, 8'hD0);
        wait_idle("R7 erase refuse idle");
        check(exp_erase.size() == 0, "R7 no erase", exp_erase.size(), 32'd0);
        check(status == 8'h86, "R12 errors sticky", {24'd0, status}, 32'h86);
        bus_wr(mk(0, 0), 8'h50);
        check(status == 8'h80, "R10 clear errors", {24'd0, status}, 32'h80);

        // R8 without protect the lock has no effect
        wr_protect = 1'b0;
        do_prog(7, 16'h0002, 8'h99, 1'b1);
        wait_idle("R8 idle");
        check(exp_prog.size() == 0, "R8 program ran", exp_prog.size(), 32'd0);
        check(status == 8'h80, "R8 no errors", {24'd0, status}, 32'h80);

        // R9 sweep skips locked blocks 0, 7, 31
        do_two(8'h77, 0, 8'hD0);
        wait_idle("R9 lock0 idle");
        do_two(8'h77, 31, 8'hD0);
        wait_idle("R9 lock31 idle");
        wr_protect = 1'b1;
        op_time = 16'd2;
        for (int b = 0; b < 32; b++)
            if (b != 0 && b != 7 && b != 31) exp_erase.push_back(5'(b));
        do_two(8'hA7, 12, 8'hD0);
        wait_idle("R9 idle");
        check(exp_erase.size() == 0, "R9 all unlocked erased", exp_erase.size(), 32'd0);
        check(status == 8'h80, "R9 no errors", {24'd0, status}, 32'h80);

        done_flag = 1'b1;
        finish_run();
    end
endmodule